// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a synchronous model of a word-wide parallel NOR flash. A host drives one shared address bus, a write strobe with write data, and a read strobe. Writes are either data or keyed commands. A command starts with a two-write unlock key. The sequencer decodes these keyed cycles into the following operations:

- identification reads
- query-table reads
- single-word program
- unlocked fast program
- sector erase
- whole-array erase
- return to normal reads

The storage is a small register-array memory that can be inferred as block RAM. It powers up erased, so every word reads as all ones.

Sector geometry is set by parameters: up to four regions, each with a sector count and a power-of-two sector size in words. The region a word falls in selects how far a sector erase reaches. Program and erase take a number of clock cycles. During that time the block raises `busy` and returns a status word on reads instead of array data. An erase in flight can be paused and resumed.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset the block is idle (`busy` low), in array-read view, and every array word reads 0xFFFF.
- R2: The key writes 0xAA at command address 0x555 and 0x55 at 0x2AA, followed by 0x90 at 0x555, enter identification view. In that view offset 0 reads 0x00BF, offset 1 reads 0x236D and other offsets read 0. Writing 0xF0 at any address returns to array reads.
- R3: Writing 0x98 at command address 0x055 enters query view. In query view:
  - offsets 0x10, 0x11 and 0x12 read 0x51, 0x52 and 0x59;
  - offset 0x27 reads log2 of the array size in bytes (7 by default);
  - offset 0x2C reads the count of regions with a non-zero sector count (4 by default).
- R4: If query view was entered from identification view, 0xF0 returns to identification view. If it was entered from array view, 0xF0 returns to array view.
- R5: A program is the key, then 0xA0 at 0x555, then a data write at the target word. The stored word becomes the old value AND the written data.
- R6: A sector erase is the key, 0x80 at 0x555, the key again, then 0x30 at any address inside the sector. It sets every word of that sector, and only that sector, to 0xFFFF. With default geometry, words 0–31 form 16-word sectors, words 32–47 form 8-word sectors, and words 48–63 form 4-word sectors.
- R7: A whole-array erase uses the same prefix as a sector erase, ending with 0x10 at 0x555. It sets every word to 0xFFFF.
- R8: Command matching uses only address bits 10:0, so 0x5555 matches 0x555 and 0x2AAA matches 0x2AA. The array word index is the low log2(depth) address bits.
- R9: The key followed by 0x20 at 0x555 enters fast-program mode:
  - in this mode, 0xA0 at any address followed by a data write programs the word;
  - 0x00 leaves the mode;
  - after leaving, a bare 0xA0 then data changes nothing.
- R10: A write that breaks a key or command sequence returns to array view and leaves the array unchanged.
- R11: Timing and status while busy:
  - a program keeps `busy` high for PROG_CYC cycles (default 4);
  - an erase keeps `busy` high one cycle per erased word;
  - reads while busy return a status word with bit 7 = 0 and bit 3 = 1, and with bits 6 and 2 inverting on each successive read.
- R12: While busy, all writes are ignored except 0xB0 during an erase. 0xB0 pauses the erase: `busy` drops and reads return array data. During the pause only 0x30 is accepted, and it resumes the erase.
- R13: A read strobe in one cycle yields `rd_valid` and `rd_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data or command byte in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result strobe, one cycle after rd_en |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench targets these corner cases:

- **AND rule on reprogramming.** It programs a word twice. A design that overwrote instead of ANDing would read 0xA5 where 0x05 is due.
- **Return from nested query view.** It leaves query view after entering it from identification view. A single-level mode register would fall back to array reads here.
- **Sector boundaries.** It erases at random addresses and checks every word of the array. An off-by-one sector base or size shows up as a stray erased or surviving word next to the target sector.
- **Keys that must be ignored.** It sends writes during a program, during a paused erase, after fast-program exit, and as broken key sequences. A design that let any of them through would enter identification view or alter a stored word.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam int CMD_W = 11;

  localparam logic [CMD_W-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMD_W-1:0] ADR_KEY_B = 11'h2AA;
  localparam logic [CMD_W-1:0] ADR_QUERY = 11'h055;

  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_WRITE   = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_FAST    = 8'h20;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_ALL     = 8'h10;
  localparam logic [7:0] OP_EXIT    = 8'hF0;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_FASTEND = 8'h00;
  localparam logic [7:0] OP_PAUSE   = 8'hB0;

  typedef enum logic [3:0] {
    ST_READ, ST_KEY1, ST_KEY2, ST_ERA1, ST_ERA2, ST_ERA3, ST_PDATA,
    ST_IDENT, ST_QUERY, ST_FAST, ST_FDATA, ST_PBUSY, ST_EBUSY, ST_EPAUSE
  } seq_state_t;

  typedef enum logic [1:0] {
    VW_ARRAY, VW_IDENT, VW_QUERY, VW_STATUS
  } view_t;
endpackage

// File: rtl/nfs_geom.sv
module nfs_geom #(
  parameter int AIW = 6,
  parameter int N0 = 2, parameter int L0 = 4,
  parameter int N1 = 2, parameter int L1 = 3,
  parameter int N2 = 2, parameter int L2 = 2,
  parameter int N3 = 2, parameter int L3 = 2
) (
  input  logic [AIW-1:0] idx,
  output logic [AIW-1:0] sec_base,
  output logic [AIW-1:0] sec_lenm1
);
  localparam int CNT [4] = '{N0, N1, N2, N3};
  localparam int LG  [4] = '{L0, L1, L2, L3};

  always_comb begin
    int ai;
    int rb;
    sec_base  = '0;
    sec_lenm1 = '0;
    rb = 0;
    ai = int'(idx);
    for (int r = 0; r < 4; r++) begin
      if (ai >= rb && ai < rb + (CNT[r] << LG[r])) begin
        sec_base  = AIW'(rb + (((ai - rb) >> LG[r]) << LG[r]));
        sec_lenm1 = AIW'((1 << LG[r]) - 1);
      end
      rb = rb + (CNT[r] << LG[r]);
    end
  end
endmodule

// File: rtl/nfs_array.sv
module nfs_array #(
  parameter int DW  = 16,
  parameter int AIW = 6
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [AIW-1:0] raddr,
  output logic [DW-1:0]  q
);
  localparam int DEPTH = 1 << AIW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/nfs_query.sv
module nfs_query
  import nfs_pkg::*;
#(
  parameter int DW = 16,
  parameter int AIW = 6,
  parameter int N0 = 2, parameter int N1 = 2,
  parameter int N2 = 2, parameter int N3 = 2,
  parameter logic [DW-1:0] MFR_ID = 16'h00BF,
  parameter logic [DW-1:0] DEV_ID = 16'h236D
) (
  input  view_t       view,
  input  logic [7:0]  ofs,
  output logic [DW-1:0] val
);
  localparam int NREG = int'(N0 != 0) + int'(N1 != 0) + int'(N2 != 0) + int'(N3 != 0);
  localparam int SIZE_LOG2 = AIW + $clog2(DW / 8);

  always_comb begin
    val = '0;
    if (view == VW_IDENT) begin
      if (ofs == 8'h00) val = MFR_ID;
      else if (ofs == 8'h01) val = DEV_ID;
    end else if (view == VW_QUERY) begin
      case (ofs)
        8'h10: val = DW'(8'h51);
        8'h11: val = DW'(8'h52);
        8'h12: val = DW'(8'h59);
        8'h27: val = DW'(SIZE_LOG2);
        8'h2C: val = DW'(NREG);
        default: val = '0;
      endcase
    end
  end
endmodule

// File: rtl/nfs_seq.sv
module nfs_seq
  import nfs_pkg::*;
#(
  parameter int DW = 16,
  parameter int AIW = 6,
  parameter int PROG_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] cmd_addr,
  input  logic [AIW-1:0]   wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [AIW-1:0]   rd_idx,
  input  logic [AIW-1:0]   sec_base,
  input  logic [AIW-1:0]   sec_lenm1,
  input  logic [DW-1:0]    mem_q,
  output logic             mem_we,
  output logic [AIW-1:0]   mem_waddr,
  output logic [DW-1:0]    mem_wdata,
  output logic [AIW-1:0]   mem_raddr,
  output logic             busy,
  output view_t            view
);
  localparam int PCW = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
  localparam logic [PCW-1:0] PC_LAST = PCW'(PROG_CYC - 1);
  localparam logic [AIW-1:0] ALL_LAST = '1;

  seq_state_t st;
  logic       query_from_ident;
  logic       back_to_fast;
  logic [PCW-1:0] pcnt;
  logic [AIW-1:0] paddr;
  logic [DW-1:0]  pdata;
  logic [AIW-1:0] ecur;
  logic [AIW-1:0] ecnt;

  logic [7:0] c;
  logic at_a, at_b, at_q;
  assign c    = wr_data[7:0];
  assign at_a = (cmd_addr == ADR_KEY_A);
  assign at_b = (cmd_addr == ADR_KEY_B);
  assign at_q = (cmd_addr == ADR_QUERY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_READ;
      query_from_ident <= 1'b0;
      back_to_fast <= 1'b0;
      pcnt <= '0;
      paddr <= '0;
      pdata <= '0;
      ecur <= '0;
      ecnt <= '0;
    end else begin
      case (st)
        ST_READ: if (wr_en) begin
          if (c == KEY_A && at_a) st <= ST_KEY1;
          else if (c == OP_QUERY && at_q) begin
            st <= ST_QUERY;
            query_from_ident <= 1'b0;
          end
        end
        ST_KEY1: if (wr_en) st <= (c == KEY_B && at_b) ? ST_KEY2 : ST_READ;
        ST_KEY2: if (wr_en) begin
          st <= ST_READ;
          if (at_a) begin
            case (c)
              OP_IDENT: st <= ST_IDENT;
              OP_WRITE: st <= ST_PDATA;
              OP_ERASE: st <= ST_ERA1;
              OP_FAST:  st <= ST_FAST;
              default:  st <= ST_READ;
            endcase
          end
        end
        ST_ERA1: if (wr_en) st <= (c == KEY_A && at_a) ? ST_ERA2 : ST_READ;
        ST_ERA2: if (wr_en) st <= (c == KEY_B && at_b) ? ST_ERA3 : ST_READ;
        ST_ERA3: if (wr_en) begin
          if (c == OP_SECTOR) begin
            st <= ST_EBUSY;
            ecur <= sec_base;
            ecnt <= sec_lenm1;
          end else if (c == OP_ALL && at_a) begin
            st <= ST_EBUSY;
            ecur <= '0;
            ecnt <= ALL_LAST;
          end else begin
            st <= ST_READ;
          end
        end
        ST_PDATA, ST_FDATA: if (wr_en) begin
          back_to_fast <= (st == ST_FDATA);
          st <= ST_PBUSY;
          pcnt <= '0;
          paddr <= wr_idx;
          pdata <= wr_data;
        end
        ST_IDENT: if (wr_en) begin
          if (c == OP_EXIT) st <= ST_READ;
          else if (c == OP_QUERY && at_q) begin
            st <= ST_QUERY;
            query_from_ident <= 1'b1;
          end
        end
        ST_QUERY: if (wr_en && c == OP_EXIT) begin
          st <= query_from_ident ? ST_IDENT : ST_READ;
          query_from_ident <= 1'b0;
        end
        ST_FAST: if (wr_en) begin
          if (c == OP_WRITE) st <= ST_FDATA;
          else if (c == OP_FASTEND) st <= ST_READ;
        end
        ST_PBUSY: begin
          if (pcnt == PC_LAST) st <= back_to_fast ? ST_FAST : ST_READ;
          else pcnt <= pcnt + 1'b1;
        end
        ST_EBUSY: begin
          if (ecnt == '0) st <= ST_READ;
          else begin
            ecur <= ecur + 1'b1;
            ecnt <= ecnt - 1'b1;
            if (wr_en && c == OP_PAUSE) st <= ST_EPAUSE;
          end
        end
        ST_EPAUSE: if (wr_en && c == OP_SECTOR) st <= ST_EBUSY;
        default: st <= ST_READ;
      endcase
    end
  end

  always_comb begin
    mem_we    = (st == ST_PBUSY && pcnt == PC_LAST) || (st == ST_EBUSY);
    mem_waddr = (st == ST_EBUSY) ? ecur : paddr;
    mem_wdata = (st == ST_EBUSY) ? '1 : (mem_q & pdata);
    mem_raddr = (st == ST_PBUSY) ? paddr : rd_idx;
    busy      = (st == ST_PBUSY) || (st == ST_EBUSY);
    case (st)
      ST_IDENT:           view = VW_IDENT;
      ST_QUERY:           view = VW_QUERY;
      ST_PBUSY, ST_EBUSY: view = VW_STATUS;
      default:            view = VW_ARRAY;
    endcase
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nfs_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int N0 = 2, parameter int L0 = 4,
  parameter int N1 = 2, parameter int L1 = 3,
  parameter int N2 = 2, parameter int L2 = 2,
  parameter int N3 = 2, parameter int L3 = 2,
  parameter int PROG_CYC = 4,
  parameter logic [DW-1:0] MFR_ID = 16'h00BF,
  parameter logic [DW-1:0] DEV_ID = 16'h236D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy
);
  localparam int DEPTH = (N0 << L0) + (N1 << L1) + (N2 << L2) + (N3 << L3);
  localparam int AIW = $clog2(DEPTH);

  logic [AIW-1:0] idx;
  logic [AIW-1:0] sec_base, sec_lenm1;
  logic           mem_we;
  logic [AIW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0]  mem_wdata, mem_q;
  logic [DW-1:0]  qval, stat_w, qv_q;
  view_t          view, vw_q;
  logic           tgl;
  logic           unused_hi;

  assign idx = addr[AIW-1:0];
  assign unused_hi = ^addr[AW-1:CMD_W];

  nfs_geom #(.AIW(AIW), .N0(N0), .L0(L0), .N1(N1), .L1(L1),
             .N2(N2), .L2(L2), .N3(N3), .L3(L3)) u_geom (
    .idx(idx), .sec_base(sec_base), .sec_lenm1(sec_lenm1));

  nfs_seq #(.DW(DW), .AIW(AIW), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_addr(addr[CMD_W-1:0]),
    .wr_idx(idx), .wr_data(wr_data), .rd_idx(idx),
    .sec_base(sec_base), .sec_lenm1(sec_lenm1), .mem_q(mem_q),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .busy(busy), .view(view));

  nfs_array #(.DW(DW), .AIW(AIW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .q(mem_q));

  nfs_query #(.DW(DW), .AIW(AIW), .N0(N0), .N1(N1), .N2(N2), .N3(N3),
              .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_query (
    .view(view), .ofs(addr[7:0]), .val(qval));

  always_comb begin
    stat_w    = '0;
    stat_w[3] = 1'b1;
    stat_w[6] = tgl;
    stat_w[2] = tgl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      vw_q     <= VW_ARRAY;
      qv_q     <= '0;
      tgl      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        vw_q <= view;
        qv_q <= (view == VW_STATUS) ? stat_w : qval;
        if (view == VW_STATUS) tgl <= ~tgl;
      end
    end
  end

  assign rd_data = (vw_q == VW_ARRAY) ? mem_q : qv_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          busy,
  input logic          mem_we
);
  p_idle_after_reset_r1: assert property (@(posedge clk) rst |=> !busy);

  p_read_latency_r13: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_no_spurious_valid_r13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_write_only_busy_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_status_bits_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(busy)) |-> (rd_data[3] && !rd_data[7]));

  p_status_toggle_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid) && $past(busy) && $past(busy, 2))
      |-> (rd_data[6] != $past(rd_data[6])));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .busy(busy), .mem_we(mem_we));

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
  localparam int PROG_CYC = 4;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  nor_cmd_seq #(.PROG_CYC(PROG_CYC)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy));

  function automatic int sbase(int a);
    if (a < 32) return (a / 16) * 16;
    else if (a < 48) return 32 + ((a - 32) / 8) * 8;
    else return (a / 4) * 4;
  endfunction

  function automatic int slen(int a);
    if (a < 32) return 16;
    else if (a < 48) return 8;
    else return 4;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic program_word(input int a, input logic [15:0] d);
    int n;
    unlock();
    wr(16'h0555, 16'h00A0);
    wr(16'(a), d);
    wait_idle(n);
    ref_mem[a] = ref_mem[a] & d;
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(16'(i), v);
      chk(req, v, ref_mem[i]);
    end
  endtask

  initial begin
    logic [15:0] v, v2;
    int n, a, b;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {15'd0, busy}, 16'd0);
    rd(16'd0, v); chk("R1 erased", v, 16'hFFFF);
    // R13 latency
    @(negedge clk); rd_en = 1'b1; addr = 16'd3;
    @(negedge clk); rd_en = 1'b0;
    chk("R13 valid", {15'd0, rd_valid}, 16'd1);
    @(negedge clk);
    chk("R13 valid drop", {15'd0, rd_valid}, 16'd0);

    // R2 identification
    unlock(); wr(16'h0555, 16'h0090);
    rd(16'd0, v); chk("R2 mfr", v, 16'h00BF);
    rd(16'd1, v); chk("R2 dev", v, 16'h236D);
    rd(16'd2, v); chk("R2 other", v, 16'h0000);
    wr(16'd0, 16'h00F0);
    rd(16'd0, v); chk("R2 exit", v, 16'hFFFF);

    // R3 query
    wr(16'h0055, 16'h0098);
    rd(16'h10, v); chk("R3 Q", v, 16'h0051);
    rd(16'h11, v); chk("R3 R", v, 16'h0052);
    rd(16'h12, v); chk("R3 Y", v, 16'h0059);
    rd(16'h27, v); chk("R3 size", v, 16'd7);
    rd(16'h2C, v); chk("R3 regions", v, 16'd4);
    wr(16'd0, 16'h00F0);
    rd(16'd0, v); chk("R4 back to array", v, 16'hFFFF);

    // R4 nested query
    unlock(); wr(16'h0555, 16'h0090);
    wr(16'h0055, 16'h0098);
    rd(16'h10, v); chk("R4 query", v, 16'h0051);
    wr(16'd0, 16'h00F0);
    rd(16'd0, v); chk("R4 ident", v, 16'h00BF);
    wr(16'd0, 16'h00F0);
    rd(16'd0, v); chk("R4 array", v, 16'hFFFF);

    // R5 AND programming, R11 program timing
    unlock(); wr(16'h0555, 16'h00A0); wr(16'd5, 16'h0055);
    wait_idle(n); chk("R11 prog cycles", 16'(n), 16'(PROG_CYC));
    ref_mem[5] = 16'h0055;
    rd(16'd5, v); chk("R5 first", v, 16'h0055);
    program_word(5, 16'h00A5);
    rd(16'd5, v); chk("R5 and", v, 16'h0005);

    // R12 writes during program ignored
    unlock(); wr(16'h0555, 16'h00A0); wr(16'd9, 16'h1234);
    ref_mem[9] = 16'h1234;
    wr(16'h0555, 16'h00AA);
    wait_idle(n);
    wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0090);
    rd(16'd0, v); chk("R12 ignored in busy", v, ref_mem[0]);
    rd(16'd9, v); chk("R5 word", v, 16'h1234);

    // R8 high bits
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    rd(16'd0, v); chk("R8 high bits", v, 16'h00BF);
    wr(16'd0, 16'h00F0);
    rd(16'h0049, v); chk("R8 index wrap", v, ref_mem[9]);

    // R9 fast program
    unlock(); wr(16'h0555, 16'h0020);
    wr(16'h0555, 16'h00A0); wr(16'd40, 16'h0123); wait_idle(n);
    ref_mem[40] = 16'h0123;
    wr(16'h0007, 16'h00A0); wr(16'd41, 16'h4567); wait_idle(n);
    ref_mem[41] = 16'h4567;
    wr(16'd0, 16'h0000);
    wr(16'h0555, 16'h00A0); wr(16'd42, 16'h0000);
    @(negedge clk);
    rd(16'd40, v); chk("R9 bypass0", v, 16'h0123);
    rd(16'd41, v); chk("R9 any addr", v, 16'h4567);
    rd(16'd42, v); chk("R9 after exit", v, 16'hFFFF);

    // R10 broken sequences
    wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055);
    wr(16'h0555, 16'h00A0); wr(16'd43, 16'h0000);
    rd(16'd43, v); chk("R10 broken key", v, 16'hFFFF);
    unlock(); wr(16'h0554, 16'h00A0); wr(16'd44, 16'h0000);
    rd(16'd44, v); chk("R10 wrong addr", v, 16'hFFFF);

    // Random phase: R5 / R10 / reads
    for (int it = 0; it < 40; it++) begin
      a = int'($urandom % DEPTH);
      case ($urandom % 3)
        0: program_word(a, 16'($urandom));
        1: begin
          wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'(8'h11 + ($urandom % 8)));
          wr(16'h0555, 16'h00A0); wr(16'(a), 16'h0000);
        end
        default: ;
      endcase
      rd(16'(a), v); chk("R5/R10 random", v, ref_mem[a]);
    end

    // R6 sector erase with status (R11)
    for (int i = 0; i < DEPTH; i++) program_word(i, 16'h0F0F);
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'd3, 16'h0030);
    rd(16'd0, v); rd(16'd0, v2);
    chk("R11 dq7", {15'd0, v[7]}, 16'd0);
    chk("R11 dq3", {15'd0, v[3]}, 16'd1);
    chk("R11 dq6", {15'd0, v[6] ^ v2[6]}, 16'd1);
    chk("R11 dq2", {15'd0, v[2] ^ v2[2]}, 16'd1);
    wait_idle(n);
    chk("R11 erase cycles", 16'(n + 4), 16'(slen(3)));
    for (int i = 0; i < 16; i++) ref_mem[i] = 16'hFFFF;
    check_all("R6 sector 0");

    for (int it = 0; it < 3; it++) begin
      a = 32 + int'($urandom % 32);
      b = sbase(a);
      unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'(a), 16'h0030);
      wait_idle(n);
      chk("R11 erase len", 16'(n), 16'(slen(a)));
      for (int i = b; i < b + slen(a); i++) ref_mem[i] = 16'hFFFF;
      check_all("R6 random sector");
    end

    // R12 pause and resume
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'd20, 16'h0030);
    rd(16'd0, v);
    wr(16'd0, 16'h00B0);
    chk("R12 paused busy", {15'd0, busy}, 16'd0);
    rd(16'd31, v); rd(16'd31, v2);
    chk("R12 stable read", v, v2);
    chk("R12 array data", v, 16'h0F0F);
    rd(16'd40, v); chk("R12 other sector", v, ref_mem[40]);
    wr(16'h0555, 16'h00AA);
    wr(16'd0, 16'h0030);
    chk("R12 resumed", {15'd0, busy}, 16'd1);
    wait_idle(n);
    for (int i = 16; i < 32; i++) ref_mem[i] = 16'hFFFF;
    wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0090);
    rd(16'd0, v); chk("R12 key ignored in pause", v, ref_mem[0]);
    check_all("R12 erase completed");

    // R7 chip erase
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h0555, 16'h0010);
    wait_idle(n);
    chk("R7 cycles", 16'(n), 16'(DEPTH));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
    check_all("R7 chip erase");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule